// File: doc/BRIEF.md
# Adaptive Walsh Decoder Effort Controller

This block closes the feedback loop around a multi-correlator Walsh decoder. After each decoded codeword it compares the six decoded bits with the six bits known to have been sent, and counts how many differ. In the adaptive mode it uses that count to raise or lower the number of active length-8 transform engines. A proportional rule toward a target error count makes this change, and the result is clamped to the legal range. Engines that are not selected can be held idle to save switching power.

The block also holds the decoding mode. A one-cycle advance pulse cycles the mode through local, optimal and adaptive, then back to local. In the local mode the engine count follows a manual setting, clamped to the legal range. In the optimal mode the count is not used and is frozen. Codewords arrive on a slow periodic enable, so the decode-done strobe is sparse compared with the clock.

Top module: `walsh_effort_ctrl`

## Requirements
- R1: While reset is applied and in the cycles after its release, the mode is local (code 0), the engine count is 8 and the error count is 0.
- R2: Each cycle with `mode_step_i` high moves the mode one place along local (0) → optimal (1) → adaptive (2) → local (0), visible on the next clock. Without a pulse the mode holds. Code 3 never appears.
- R3: On a cycle with `dec_done_i` high, `err_count_o` takes the number of bit positions where `dec_bits_i` and `ref_bits_i` differ (0 to 6) on the next clock, in every mode. Otherwise it holds.
- R4: In the adaptive mode, on `dec_done_i` the count becomes clamp(count + s). Here d = errors − TARGET (TARGET = 1) and s = sign(d)·ceil(|d| / 2^GAIN_SHIFT) with GAIN_SHIFT = 1, so any nonzero d moves the count by at least one. When d = 0 the count is unchanged.
- R5: The engine count always lies between 2 and 8 inclusive.
- R6: In the local mode, one clock after each cycle the count equals `manual_cnt_i` clamped to 2..8.
- R7: In the optimal mode the count holds, whatever `manual_cnt_i` and `dec_done_i` do.
- R8: In the adaptive mode the count holds in cycles without `dec_done_i`.
- R9: When `mode_step_i` and a count update fall in the same cycle, the count update follows the mode that held before the step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dec_bits_i | input | 6 | Bits produced by the decoder for the current codeword |
| ref_bits_i | input | 6 | Bits actually transmitted for that codeword |
| dec_done_i | input | 1 | One-cycle strobe: decoded and reference bits are valid |
| mode_step_i | input | 1 | One-cycle pulse advancing the mode |
| manual_cnt_i | input | 4 | Engine count requested in local mode |
| mode_o | output | 2 | Current mode: 0 local, 1 optimal, 2 adaptive |
| fht_count_o | output | 4 | Number of active length-8 transform engines |
| err_count_o | output | 3 | Bit errors of the last decoded codeword |

## Verification
The mode sequencer and the count update can act on the same clock edge. This happens when a mode-advance pulse coincides with a decode-done strobe, or with the continuous manual load of the local mode. The bench forces these coincidences in directed steps, for example a strobe with six errors in the very cycle that adaptive mode is left. It also produces them at random with independent pulse probabilities. It judges each one against a model that applies the count rule of the mode in force before the step.

// File: rtl/effort_pkg.sv
package effort_pkg;
  typedef enum logic [1:0] {
    MODE_LOCAL    = 2'd0,
    MODE_OPTIMAL  = 2'd1,
    MODE_ADAPTIVE = 2'd2
  } dec_mode_e;

  function automatic dec_mode_e mode_after(input dec_mode_e cur);
    case (cur)
      MODE_LOCAL:   mode_after = MODE_OPTIMAL;
      MODE_OPTIMAL: mode_after = MODE_ADAPTIVE;
      default:      mode_after = MODE_LOCAL;
    endcase
  endfunction
endpackage

// File: rtl/effort_err_tally.sv
module effort_err_tally #(
  parameter int NBITS = 6,
  parameter int ERR_W = $clog2(NBITS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             done_i,
  input  logic [NBITS-1:0] dec_i,
  input  logic [NBITS-1:0] ref_i,
  output logic [ERR_W-1:0] err_now_o,
  output logic [ERR_W-1:0] err_q_o
);
  logic [NBITS-1:0] diff;
  logic [ERR_W-1:0] err_d;

  always_comb begin
    diff      = dec_i ^ ref_i;
    err_now_o = '0;
    for (int i = 0; i < NBITS; i++) begin
      err_now_o = err_now_o + ERR_W'(diff[i]);
    end
    err_d = done_i ? err_now_o : err_q_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q_o <= '0;
    else         err_q_o <= err_d;
  end

  AST_ERR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> $stable(err_q_o)); // R3
  AST_ERR_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q_o <= ERR_W'(NBITS)); // R3
endmodule

// File: rtl/effort_mode_seq.sv
module effort_mode_seq
  import effort_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      step_i,
  output dec_mode_e mode_q_o
);
  dec_mode_e mode_d;

  always_comb begin
    mode_d = step_i ? mode_after(mode_q_o) : mode_q_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q_o <= MODE_LOCAL;
    else         mode_q_o <= mode_d;
  end

  AST_MODE_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> mode_q_o == mode_after($past(mode_q_o))); // R2
  AST_MODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(mode_q_o)); // R2
  AST_MODE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q_o != 2'd3); // R2
endmodule

// File: rtl/effort_law.sv
module effort_law #(
  parameter int CNT_W      = 4,
  parameter int ERR_W      = 3,
  parameter int MIN_CNT    = 2,
  parameter int MAX_CNT    = 8,
  parameter int TARGET     = 1,
  parameter int GAIN_SHIFT = 1
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [ERR_W-1:0] err_i,
  input  logic [CNT_W-1:0] manual_i,
  output logic [CNT_W-1:0] adapt_o,
  output logic [CNT_W-1:0] manual_o
);
  localparam int SW = CNT_W + ERR_W + 2;
  localparam logic signed [SW-1:0] TGT_S = SW'(TARGET);
  localparam logic signed [SW-1:0] RND_S = SW'((1 << GAIN_SHIFT) - 1);
  localparam logic signed [SW-1:0] MIN_S = SW'(MIN_CNT);
  localparam logic signed [SW-1:0] MAX_S = SW'(MAX_CNT);

  logic signed [SW-1:0] err_s, cnt_s, delta, mag, step, sum;

  always_comb begin
    err_s = signed'({{(SW-ERR_W){1'b0}}, err_i});
    cnt_s = signed'({{(SW-CNT_W){1'b0}}, cnt_i});
    delta = err_s - TGT_S;
    mag   = (delta < 0) ? -delta : delta;
    step  = (mag + RND_S) >>> GAIN_SHIFT;
    if (delta < 0) step = -step;
    sum   = cnt_s + step;
    if (sum < MIN_S)      sum = MIN_S;
    else if (sum > MAX_S) sum = MAX_S;
    adapt_o = sum[CNT_W-1:0];

    if (manual_i < CNT_W'(MIN_CNT))      manual_o = CNT_W'(MIN_CNT);
    else if (manual_i > CNT_W'(MAX_CNT)) manual_o = CNT_W'(MAX_CNT);
    else                                 manual_o = manual_i;
  end
endmodule

// File: rtl/walsh_effort_ctrl.sv
module walsh_effort_ctrl
  import effort_pkg::*;
#(
  parameter int NBITS      = 6,
  parameter int CNT_W      = 4,
  parameter int MIN_CNT    = 2,
  parameter int MAX_CNT    = 8,
  parameter int TARGET     = 1,
  parameter int GAIN_SHIFT = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NBITS-1:0] dec_bits_i,
  input  logic [NBITS-1:0] ref_bits_i,
  input  logic             dec_done_i,
  input  logic             mode_step_i,
  input  logic [CNT_W-1:0] manual_cnt_i,
  output logic [1:0]       mode_o,
  output logic [CNT_W-1:0] fht_count_o,
  output logic [$clog2(NBITS+1)-1:0] err_count_o
);
  localparam int ERR_W = $clog2(NBITS + 1);

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  dec_mode_e        mode_q;
  logic [ERR_W-1:0] err_now, err_q;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_adapt, cnt_manual;

  effort_mode_seq u_mode (
    .clk_i(clk_i), .rst_ni(rst_n), .step_i(mode_step_i), .mode_q_o(mode_q)
  );

  effort_err_tally #(.NBITS(NBITS), .ERR_W(ERR_W)) u_tally (
    .clk_i(clk_i), .rst_ni(rst_n), .done_i(dec_done_i),
    .dec_i(dec_bits_i), .ref_i(ref_bits_i),
    .err_now_o(err_now), .err_q_o(err_q)
  );

  effort_law #(
    .CNT_W(CNT_W), .ERR_W(ERR_W), .MIN_CNT(MIN_CNT), .MAX_CNT(MAX_CNT),
    .TARGET(TARGET), .GAIN_SHIFT(GAIN_SHIFT)
  ) u_law (
    .cnt_i(cnt_q), .err_i(err_now), .manual_i(manual_cnt_i),
    .adapt_o(cnt_adapt), .manual_o(cnt_manual)
  );

  // next count: selected by the mode before any step in this cycle (R9)
  always_comb begin
    cnt_d = cnt_q;
    case (mode_q)
      MODE_LOCAL:    cnt_d = cnt_manual;
      MODE_ADAPTIVE: if (dec_done_i) cnt_d = cnt_adapt;
      default:       cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) cnt_q <= CNT_W'(MAX_CNT);
    else        cnt_q <= cnt_d;
  end

  assign mode_o      = mode_q;
  assign fht_count_o = cnt_q;
  assign err_count_o = err_q;

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_n)
    (cnt_q >= CNT_W'(MIN_CNT)) && (cnt_q <= CNT_W'(MAX_CNT))); // R5
  AST_OPT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n)
    (mode_q == MODE_OPTIMAL) |=> $stable(cnt_q)); // R7
  AST_ADAPT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_n)
    (mode_q == MODE_ADAPTIVE && !dec_done_i) |=> $stable(cnt_q)); // R8
  AST_ADAPT_ON_TARGET: assert property (@(posedge clk_i) disable iff (!rst_n)
    (mode_q == MODE_ADAPTIVE && dec_done_i && err_now == ERR_W'(TARGET))
      |=> $stable(cnt_q)); // R4
endmodule

// File: tb/walsh_effort_ctrl_bench.sv
module walsh_effort_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] dec_bits, ref_bits;
  logic       dec_done, mode_step;
  logic [3:0] manual_cnt;
  logic [1:0] mode;
  logic [3:0] fht_count;
  logic [2:0] err_count;

  int checks = 0;
  int errors = 0;
  int exp_mode, exp_cnt, exp_err;

  always #4 clk = ~clk;

  walsh_effort_ctrl u_walsh_effort_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .dec_bits_i(dec_bits), .ref_bits_i(ref_bits),
    .dec_done_i(dec_done), .mode_step_i(mode_step), .manual_cnt_i(manual_cnt),
    .mode_o(mode), .fht_count_o(fht_count), .err_count_o(err_count)
  );

  function automatic int popc(input logic [5:0] v);
    int n = 0;
    for (int i = 0; i < 6; i++) n += int'(v[i]);
    return n;
  endfunction

  function automatic int clampc(input int v);
    if (v < 2) return 2;
    if (v > 8) return 8;
    return v;
  endfunction

  function automatic int adapt_next(input int cnt, input int err);
    int d = err - 1;
    int m = (d < 0) ? -d : d;
    int s = (m + 1) >> 1;
    return clampc(cnt + ((d < 0) ? -s : s));
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // apply one cycle of stimulus, update the model, compare after the edge
  task automatic step(input logic done, input logic [5:0] d, input logic [5:0] r,
                      input logic stp, input logic [3:0] man);
    string creq;
    dec_done = done; dec_bits = d; ref_bits = r; mode_step = stp; manual_cnt = man;
    @(posedge clk);
    if (stp && (exp_mode != 1)) creq = "R9";
    else if (exp_mode == 0) creq = "R6";
    else if (exp_mode == 1) creq = "R7";
    else if (done) creq = "R4";
    else creq = "R8";
    if (exp_mode == 0) exp_cnt = clampc(int'(man));
    else if (exp_mode == 2 && done) exp_cnt = adapt_next(exp_cnt, popc(d ^ r));
    if (done) exp_err = popc(d ^ r);
    if (stp) exp_mode = (exp_mode + 1) % 3;
    #2;
    check("R2", "mode", int'(mode), exp_mode);
    check(creq, "count", int'(fht_count), exp_cnt);
    check("R3", "errors", int'(err_count), exp_err);
    check("R5", "count range", int'(fht_count >= 2 && fht_count <= 8), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    logic [5:0] rb;
    seed = 32'h5eed_0017;
    void'($urandom(seed));
    rst_n = 1'b0; dec_done = 0; mode_step = 0; dec_bits = 0; ref_bits = 0;
    manual_cnt = 4'd5;
    repeat (3) @(posedge clk);
    #2;
    check("R1", "mode in reset", int'(mode), 0);
    check("R1", "count in reset", int'(fht_count), 8);
    check("R1", "errors in reset", int'(err_count), 0);
    rst_n = 1'b1;
    exp_mode = 0; exp_cnt = 8; exp_err = 0;
    repeat (2) @(posedge clk);
    #2;
    check("R1", "count after release", int'(fht_count), 8);

    // R6: local mode, including out-of-range manual values
    step(0, 0, 0, 0, 4'd0);
    step(0, 0, 0, 0, 4'd15);
    step(0, 0, 0, 0, 4'd5);
    // R7: into optimal, manual and strobes have no effect
    step(0, 0, 0, 1, 4'd3);
    step(1, 6'h3f, 6'h00, 0, 4'd2);
    step(0, 0, 0, 0, 4'd9);
    // into adaptive (R2)
    step(0, 0, 0, 1, 4'd7);
    // R4: six errors drive the count to the top
    for (int k = 0; k < 4; k++) step(1, 6'h3f, 6'h00, 0, 4'd2);
    // R4: exactly target errors, no change
    step(1, 6'h01, 6'h00, 0, 4'd2);
    // R4: zero errors step down to the floor
    for (int k = 0; k < 8; k++) step(1, 6'h15, 6'h15, 0, 4'd2);
    // R8: idle adaptive
    step(0, 6'h3f, 6'h00, 0, 4'd8);
    // R9: strobe with errors while leaving adaptive
    step(1, 6'h3f, 6'h00, 1, 4'd4);
    step(0, 0, 0, 0, 4'd4);

    for (int n = 0; n < 3000; n++) begin
      rb = 6'($urandom);
      step(($urandom % 3) == 0,
           rb ^ (($urandom % 2) == 0 ? 6'(1 << ($urandom % 6)) : 6'($urandom)),
           rb, ($urandom % 8) == 0, 4'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule